// File: doc/BRIEF.md
# Interpolating log-sum correction unit

This unit produces the correction term used when two positive numbers held as base-2 logarithms are added: given the log-domain difference Z, it returns log2(1 + 2^Z). Values of that function are tabulated at a fixed step of 1/16 and held in one table built at elaboration. The table is read at two neighbouring points in the same cycle. Their difference gives the local slope. The slope times the fine part of Z, added to the lower point, gives a straight-line estimate between the two points.

Z is a 20-bit two's-complement number with 12 fractional bits. Only the magnitude of Z addresses the table. For negative Z the unit applies log2(1 + 2^-A) = log2(1 + 2^A) - A, where A = |Z|. Above a magnitude of 12.0 the function is indistinguishable from its asymptote at this precision, so the table is not used. A caller feeds one Z per cycle with a valid strobe. Each result comes out three cycles later, with 22 fractional bits. The ten bits below the 12-bit working precision act as guard bits for a later rounding step.

Top module: `lns_sb_interp`

## Requirements
- R1: `out_valid` is low from reset until results arrive. It equals `in_valid` from exactly three cycles earlier. A result appears on `out_sb` in the cycle its `out_valid` is high.
- R2: For 0 <= Z <= 12.0, `out_sb` is unsigned with 22 fractional bits (value = out_sb / 2^22). It is within 2^-12 of log2(1 + 2^Z).
- R3: For Z > 12.0 (Z above 0x0C000), `out_sb` equals Z exactly, i.e. Z shifted left by 10 bits.
- R4: For -12.0 <= Z < 0, `out_sb` is within 2^-12 of log2(1 + 2^Z).
- R5: For Z < -12.0, `out_sb` is exactly zero.
- R6: When the low 8 fraction bits of |Z| are zero and |Z| <= 12.0 (a tabulated point), the low 8 bits of `out_sb` are zero. For Z >= 0 the value is within 2^-15 + 2^-22 of the exact function. Z = 0 gives exactly 1.0 (0x400000).
- R7: Z = 12.0 exactly (0x0C000) takes the table path, so `out_sb` differs from 12.0 (0x3000000) and still meets R2.
- R8: For 0 <= Z <= 12.0, Z <= out_sb value <= Z + 1.
- R9: A new input is accepted every cycle. Back-to-back valid inputs each produce their own result, in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Z on `in_z` is to be processed |
| in_z | input | 20 | Z, two's complement, 12 fractional bits |
| out_valid | output | 1 | `out_sb` holds a result |
| out_sb | output | 29 | log2(1 + 2^Z), unsigned, 22 fractional bits |

## Verification
Every result is due exactly three cycles after its input. The table read is registered at the first edge, the slope and product at the second, and the select and add at the third. The bench drives inputs on falling edges. It keeps a three-entry record of what it drove, and on every falling edge it compares `out_valid` and `out_sb` against the entry from three falling edges earlier. Exact values are checked for the bypass and zero cases, and a real-valued reference with tolerance is used on the table path.

// File: rtl/lns_sb_pkg.sv
`timescale 1ns/1ps
package lns_sb_pkg;

    // Z format: sign, integer bits, fractional bits
    localparam int FRAC_W     = 12;
    localparam int INT_W      = 7;
    localparam int Z_W        = 1 + INT_W + FRAC_W;
    // table spacing 2^-SEG_FRAC, address integer span
    localparam int SEG_FRAC   = (FRAC_W - 4) / 2;
    localparam int ADDR_INT_W = 4;
    localparam int ADDR_W     = ADDR_INT_W + SEG_FRAC;
    localparam int DEPTH      = 1 << ADDR_W;
    // table entries carry two guard bits beyond working precision
    localparam int ENT_GUARD  = 2;
    localparam int ENT_FRAC   = FRAC_W + ENT_GUARD;
    localparam int ENT_W      = ADDR_INT_W + ENT_FRAC;
    // fine part of Z and slope operand
    localparam int ZL_W       = FRAC_W - SEG_FRAC;
    localparam int SLOPE_W    = ZL_W + 1;
    localparam int DIFF_W     = ENT_FRAC - SEG_FRAC + 1;
    localparam int SLOPE_DROP = DIFF_W - SLOPE_W;
    localparam int PROD_W     = SLOPE_W + ZL_W;
    // result format
    localparam int OUT_FRAC   = ENT_FRAC + ZL_W;
    localparam int OUT_W      = INT_W + OUT_FRAC;
    localparam int SUM_W      = OUT_W + 2;
    // magnitude above which the asymptote is used
    localparam int LIMIT_INT  = FRAC_W;
    localparam logic [Z_W-1:0] LIMIT = Z_W'(LIMIT_INT) << FRAC_W;

    typedef struct packed {
        logic           vld;
        logic           neg;
        logic           byp;
        logic [Z_W-1:0] mag;
    } side_t;

    // rounded log2(1 + 2^(idx * 2^-SEG_FRAC)) with ENT_FRAC fraction bits
    function automatic logic [ENT_W-1:0] sb_entry(input int idx);
        real zr;
        real v;
        zr = real'(idx) / real'(1 << SEG_FRAC);
        v  = $ln(1.0 + $pow(2.0, zr)) / $ln(2.0);
        return ENT_W'($rtoi(v * real'(1 << ENT_FRAC) + 0.5));
    endfunction

endpackage

// File: rtl/lns_sb_table.sv
`timescale 1ns/1ps
module lns_sb_table
    import lns_sb_pkg::*;
(
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic [ENT_W-1:0]  q_a,
    output logic [ENT_W-1:0]  q_b
);

    logic [ENT_W-1:0] rom [DEPTH];

    // contents fixed at elaboration, one constant per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [ENT_W-1:0] VAL = sb_entry(g);
        assign rom[g] = VAL;
    end

    // two independent registered read ports
    always_ff @(posedge clk) begin
        q_a <= rom[addr_a];
        q_b <= rom[addr_b];
    end

endmodule

// File: rtl/lns_sb_slope.sv
`timescale 1ns/1ps
module lns_sb_slope
    import lns_sb_pkg::*;
(
    input  logic              clk,
    input  logic [ENT_W-1:0]  pt_lo,
    input  logic [ENT_W-1:0]  pt_hi,
    input  logic [ZL_W-1:0]   fine,
    output logic [ENT_W-1:0]  base,
    output logic [PROD_W-1:0] prod
);

    logic [DIFF_W-1:0]  rise;
    logic [SLOPE_W-1:0] slope;

    // function is increasing, so the rise is never negative and fits DIFF_W
    always_comb begin
        rise  = DIFF_W'(pt_hi - pt_lo);
        slope = SLOPE_W'(rise >> SLOPE_DROP);
    end

    always_ff @(posedge clk) begin
        base <= pt_lo;
        prod <= PROD_W'(slope) * PROD_W'(fine);
    end

endmodule

// File: rtl/lns_sb_merge.sv
`timescale 1ns/1ps
module lns_sb_merge
    import lns_sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  side_t             side,
    input  logic [ENT_W-1:0]  base,
    input  logic [PROD_W-1:0] prod,
    output logic              res_vld,
    output logic [OUT_W-1:0]  res
);

    typedef enum logic [1:0] {
        PATH_POS_TBL = 2'b00,
        PATH_NEG_TBL = 2'b01,
        PATH_POS_BYP = 2'b10,
        PATH_NEG_BYP = 2'b11
    } path_e;

    path_e            path;
    logic [SUM_W-1:0] interp;
    logic [SUM_W-1:0] magw;
    logic [SUM_W-1:0] less;
    logic [OUT_W-1:0] nxt;

    always_comb begin
        path   = path_e'({side.byp, side.neg});
        interp = (SUM_W'(base) << ZL_W) + (SUM_W'(prod) << SLOPE_DROP);
        magw   = SUM_W'(side.mag) << (OUT_FRAC - FRAC_W);
        less   = interp - magw;
        nxt    = '0;
        unique case (path)
            PATH_POS_TBL: nxt = OUT_W'(interp);
            PATH_NEG_TBL: nxt = less[SUM_W-1] ? '0 : OUT_W'(less);
            PATH_POS_BYP: nxt = OUT_W'(magw);
            PATH_NEG_BYP: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
        end else begin
            res_vld <= side.vld;
        end
    end

    always_ff @(posedge clk) begin
        res <= nxt;
    end

endmodule

// File: rtl/lns_sb_interp.sv
`timescale 1ns/1ps
module lns_sb_interp
    import lns_sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [Z_W-1:0]   in_z,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sb
);

    side_t              side_in;
    side_t              side_s1;
    side_t              side_s2;
    logic [ADDR_W-1:0]  addr_lo;
    logic [ADDR_W-1:0]  addr_hi;
    logic [ZL_W-1:0]    fine_s1;
    logic [ENT_W-1:0]   pt_lo;
    logic [ENT_W-1:0]   pt_hi;
    logic [ENT_W-1:0]   base_s2;
    logic [PROD_W-1:0]  prod_s2;

    // input decode: magnitude, sign, bypass and the two table addresses
    always_comb begin
        side_in.vld = in_valid;
        side_in.neg = in_z[Z_W-1];
        side_in.mag = in_z[Z_W-1] ? (~in_z + Z_W'(1)) : in_z;
        side_in.byp = side_in.mag > LIMIT;
        addr_lo     = side_in.mag[ADDR_W+ZL_W-1:ZL_W];
        // upper neighbour saturates at the last entry
        addr_hi     = (&addr_lo) ? addr_lo : addr_lo + ADDR_W'(1);
    end

    // stage 1: table read alongside side band
    lns_sb_table u_tbl (
        .clk    (clk),
        .addr_a (addr_lo),
        .addr_b (addr_hi),
        .q_a    (pt_lo),
        .q_b    (pt_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_s1.vld <= 1'b0;
            side_s2.vld <= 1'b0;
        end else begin
            side_s1.vld <= side_in.vld;
            side_s2.vld <= side_s1.vld;
        end
    end

    always_ff @(posedge clk) begin
        side_s1.neg <= side_in.neg;
        side_s1.byp <= side_in.byp;
        side_s1.mag <= side_in.mag;
        fine_s1     <= side_in.mag[ZL_W-1:0];
        side_s2.neg <= side_s1.neg;
        side_s2.byp <= side_s1.byp;
        side_s2.mag <= side_s1.mag;
    end

    // stage 2: slope from neighbour difference, times fine part
    lns_sb_slope u_slope (
        .clk   (clk),
        .pt_lo (pt_lo),
        .pt_hi (pt_hi),
        .fine  (fine_s1),
        .base  (base_s2),
        .prod  (prod_s2)
    );

    // stage 3: add, sign identity, bypass select
    lns_sb_merge u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .side    (side_s2),
        .base    (base_s2),
        .prod    (prod_s2),
        .res_vld (out_valid),
        .res     (out_sb)
    );

endmodule

// File: rtl/lns_sb_interp_chk.sv
`timescale 1ns/1ps
module lns_sb_interp_chk
    import lns_sb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [Z_W-1:0]   in_z,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_sb
);

    logic [1:0]       since_rst;
    logic             v1, v2, v3;
    logic [Z_W-1:0]   z1, z2, z3;
    logic             ready;
    logic [OUT_W:0]   z_scaled;
    logic [OUT_W:0]   z_plus_one;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            v1 <= in_valid; v2 <= v1; v3 <= v2;
        end
        z1 <= in_z; z2 <= z1; z3 <= z2;
    end

    always_comb begin
        ready      = (since_rst == 2'd3);
        z_scaled   = {1'b0, z3[Z_W-2:0], {(OUT_FRAC-FRAC_W){1'b0}}};
        z_plus_one = z_scaled + ((OUT_W+1)'(1) << OUT_FRAC);
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (out_valid == v3));

    p_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !out_valid);

    p_big_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && v3 && !z3[Z_W-1] && z3 > LIMIT) |-> ({1'b0, out_sb} == z_scaled));

    p_big_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && v3 && z3[Z_W-1] && (~z3 + Z_W'(1)) > LIMIT) |-> (out_sb == '0));

    p_zero_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && v3 && z3 == '0) |-> (out_sb == OUT_W'(1) << OUT_FRAC));

    p_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && v3 && !z3[Z_W-1] && z3 <= LIMIT) |->
            ({1'b0, out_sb} >= z_scaled && {1'b0, out_sb} <= z_plus_one));

endmodule

bind lns_sb_interp lns_sb_interp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_z      (in_z),
    .out_valid (out_valid),
    .out_sb    (out_sb)
);

// File: tb/sim_lns_sb_interp.sv
`timescale 1ns/1ps
module sim_lns_sb_interp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_z = '0;
    logic        out_valid;
    logic [28:0] out_sb;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic        pv [1:3];
    logic [19:0] pz [1:3];

    always #4 clk = ~clk;

    lns_sb_interp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_z(in_z),
        .out_valid(out_valid), .out_sb(out_sb)
    );

    function automatic real sb_ref(input real zr);
        return $ln(1.0 + $pow(2.0, zr)) / $ln(2.0);
    endfunction

    task automatic chk_exact(input bit ok, input string tag, input logic [28:0] got, input logic [28:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic chk_real(input string tag, input real got, input real exp, input real tol);
        real e;
        tests++;
        e = got - exp;
        if (e < 0.0) e = -e;
        if (e > tol) begin
            fails++;
            $display("FAIL %s got=%.8f exp=%.8f", tag, got, exp);
        end
    endtask

    task automatic check_result(input logic [19:0] z);
        int          zi;
        int          mag;
        real         zr;
        real         got;
        logic [28:0] zsh;
        zi  = $signed(z);
        mag = (zi < 0) ? -zi : zi;
        zr  = real'(zi) / 4096.0;
        got = real'(out_sb) / 4194304.0;
        zsh = {z[18:0], 10'b0};
        if (zi > 0 && mag > 32'hC000) begin
            chk_exact(out_sb == zsh, "R3 bypass equals Z", out_sb, zsh);
        end else if (zi < 0 && mag > 32'hC000) begin
            chk_exact(out_sb == '0, "R5 large negative gives zero", out_sb, '0);
        end else begin
            if (zi == 0)
                chk_exact(out_sb == 29'h400000, "R6 zero gives one", out_sb, 29'h400000);
            if (zi == 32'hC000)
                chk_exact(out_sb != 29'h3000000, "R7 twelve uses table", out_sb, 29'h3000000);
            if ((mag % 256) == 0) begin
                chk_exact(out_sb[7:0] == 8'h0, "R6 grid point low bits", out_sb, {out_sb[28:8], 8'h0});
                if (zi >= 0)
                    chk_real("R6 grid point accuracy", got, sb_ref(zr), 1.0/32768.0 + 1.0/4194304.0);
            end
            if (zi >= 0) begin
                chk_real("R2 table path accuracy", got, sb_ref(zr), 1.0/4096.0);
                tests++;
                if (got < zr || got > zr + 1.0) begin
                    fails++;
                    $display("FAIL R8 bounds got=%.8f exp=[%.8f,%.8f]", got, zr, zr + 1.0);
                end
            end else begin
                chk_real("R4 negative identity accuracy", got, sb_ref(zr), 1.0/4096.0);
            end
        end
    endtask

    function automatic logic [19:0] directed_z(input int i);
        case (i)
            0:  return 20'h00000;
            1:  return 20'h0C000;
            2:  return 20'h0C001;
            3:  return 20'h0BFFF;
            4:  return -20'h0C000;
            5:  return -20'h0C001;
            6:  return 20'h7FFFF;
            7:  return 20'h80000;
            8:  return 20'h00100;
            9:  return 20'h00FFF;
            10: return 20'h000FF;
            11: return -20'h00100;
            12: return 20'h05A00;
            13: return -20'h000FF;
            default: return 20'h00001;
        endcase
    endfunction

    function automatic logic [19:0] random_z();
        int unsigned r;
        r = $urandom % 10;
        if (r < 6)       return 20'($urandom % 32'hC001);
        else if (r < 8)  return 20'(-int'($urandom % 32'hC001));
        else if (r < 9)  return 20'(32'hC001 + ($urandom % (32'h7FFFF - 32'hC000)));
        else             return 20'(-int'(32'hC001 + ($urandom % (32'h80000 - 32'hC000))));
    endfunction

    // one falling edge: check outputs due now, then drive the next input
    task automatic step(input logic v, input logic [19:0] z);
        @(negedge clk);
        if (rst_n) begin
            tests++;
            if (out_valid !== pv[3]) begin
                fails++;
                $display("FAIL R1 R9 valid timing got=%0b exp=%0b", out_valid, pv[3]);
            end
            if (pv[3] && out_valid) check_result(pz[3]);
        end
        pv[3] = pv[2]; pz[3] = pz[2];
        pv[2] = pv[1]; pz[2] = pz[1];
        pv[1] = v;     pz[1] = z;
        in_valid = v;
        in_z     = z;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 1; i <= 3; i++) begin pv[i] = 1'b0; pz[i] = '0; end
        repeat (4) @(negedge clk);
        tests++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset valid got=%0b exp=0", out_valid);
        end
        rst_n = 1'b1;
        // directed corners, back to back (R9)
        for (int i = 0; i < 15; i++) step(1'b1, directed_z(i));
        step(1'b0, '0);
        // every tabulated point on both signs (R6)
        for (int k = 0; k <= 192; k++) step(1'b1, 20'(k * 256));
        for (int k = 1; k <= 192; k++) step(1'b1, 20'(-(k * 256)));
        // constrained random with gaps
        for (int n = 0; n < 5000; n++) begin
            if (($urandom % 8) == 0) step(1'b0, random_z());
            else                     step(1'b1, random_z());
        end
        for (int n = 0; n < 5; n++) step(1'b0, '0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule